// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM

This block is a synthesizable behavioral model of a synchronous static memory with flow-through reads and a one-cycle write latency. A read command returns its word in the cycle that follows the clock edge that took the command. A write command registers its address and lane enables on one edge, and its data is taken on the next edge. Both operations therefore occupy the data path one cycle after the command, so reads and writes can follow each other in any order with no idle bus cycle between them.

Commands are loaded when `adv` is low and gated by three chip selects. With `adv` high the block continues the current burst: it keeps the read or write type, steps a 2-bit offset inside the aligned group of four words, and ignores the selects and `rd_wr_n`. A `stall` input freezes all internal state. Captured write data waits in a pending register until the next enabled edge, and a read of that word takes the pending bytes lane by lane. The read bus is separate from the write bus. `rdata_drv` marks the cycles in which the model would drive the shared pins, and `rdata` is zero in the other cycles.

Top module: `lwft_sram`

## Requirements
- R1: Synchronous active-low reset leaves the block idle. `rdata_drv` is low in the cycle after any edge at which `rst_n` is low.
- R2: A read load (`adv`=0, all selected, `rd_wr_n`=1, `stall`=0) makes the addressed word appear on `rdata`, with `rdata_drv` high, in the cycle right after that edge, provided `oe_n` is low.
- R3: A write load (`rd_wr_n`=0) registers the address and the lane enables. `wdata` is sampled at the next enabled edge.
- R4: A read of an address whose write data was taken at the same edge returns the new data. Each lane that the write enabled comes from the pending data.
- R5: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load with any select inactive makes the block idle: `rdata_drv` stays low and nothing is written.
- R6: With `adv`=1 the block keeps the burst type and advances the word offset. The selects and `rd_wr_n` are ignored. Offset bits [1:0] follow start XOR count (LINEAR_BURST=0, the default) or start plus count modulo 4 (LINEAR_BURST=1), and they wrap after four beats.
- R7: A continue cycle that follows a deselect stays deselected.
- R8: A write beat with both `lane_we_n` bits high writes nothing.
- R9: With `stall`=1 every register holds. An active read keeps driving the same word, and no write commits.
- R10: `rdata_drv` is low whenever `oe_n` is high, and during every write beat whatever the value of `oe_n`.
- R11: `lane_we_n[0]` (active low) enables bits [8:0] and `lane_we_n[1]` enables bits [17:9]. Only enabled lanes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | 1 = hold all state this edge |
| adv | input | 1 | 0 = load new command, 1 = continue burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (on loads) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| addr | input | AW (6) | Word address |
| wdata | input | 18 | Write data, sampled one edge after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data, zero when not driven |
| rdata_drv | output | 1 | Read bus driven this cycle |

## Verification
A command applied before edge k produces its read word and `rdata_drv` in the cycle after edge k. The data of a write applied before edge k is taken at edge k+1 and can be read back in the cycle after edge k+1, through the pending path. The bench holds each input set across one rising edge and samples 3 ns after that edge. A table row is therefore compared with the effect of its own edge, and the rows that carry write data name the command of the previous row. A bench-side model that advances once per edge gives the expected value for every cycle of the random mix. That model commits write data at the data edge and only compares lanes that have been written.

// File: rtl/lwft_pkg.sv
// Shared types for the late-write flow-through SRAM.
// Assumes: one beat type per registered command stage.
package lwft_pkg;
    typedef enum logic [1:0] {
        BEAT_IDLE = 2'd0,
        BEAT_RD   = 2'd1,
        BEAT_WR   = 2'd2
    } beat_e;
endpackage

// File: rtl/lwft_burst_addr.sv
// Forms the current beat address from the burst start and the 2-bit beat count.
// Assumes AW >= 2; LINEAR selects sum order, otherwise XOR order.
module lwft_burst_addr #(
    parameter int AW     = 6,
    parameter bit LINEAR = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    cnt,
    output logic [AW-1:0] beat_addr
);
    logic [1:0] low;

    generate
        if (LINEAR) begin : g_linear
            // sum order, modulo four
            assign low = base[1:0] + cnt;
        end else begin : g_interleave
            // XOR order
            assign low = base[1:0] ^ cnt;
        end
    endgenerate

    assign beat_addr = {base[AW-1:2], low};
endmodule

// File: rtl/lwft_cmd_stage.sv
// Command register: decodes load/continue, keeps the burst type, start address,
// beat count and the lane enables of the current beat.
// Assumes: stall freezes everything; reset is synchronous and active low.
module lwft_cmd_stage #(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               adv,
    input  logic               rd_wr_n,
    input  logic               selected,
    input  logic [LANES-1:0]   lane_we_n,
    input  logic [AW-1:0]      addr,
    output lwft_pkg::beat_e    beat,
    output logic [AW-1:0]      base,
    output logic [1:0]         cnt,
    output logic [LANES-1:0]   beat_we_n
);
    // register a new command or advance the burst on each enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat      <= lwft_pkg::BEAT_IDLE;
            base      <= '0;
            cnt       <= '0;
            beat_we_n <= '1;
        end else if (!stall) begin
            beat_we_n <= lane_we_n;
            if (!adv) begin
                base <= addr;
                cnt  <= '0;
                if (!selected)
                    beat <= lwft_pkg::BEAT_IDLE;
                else if (rd_wr_n)
                    beat <= lwft_pkg::BEAT_RD;
                else
                    beat <= lwft_pkg::BEAT_WR;
            end else begin
                cnt <= cnt + 2'd1;
            end
        end
    end
endmodule

// File: rtl/lwft_wr_pend.sv
// Pending-write register: holds data taken one edge after a write command until
// the next enabled edge commits it, and merges it into reads of the same word.
// Assumes: mask bit set = lane written.
module lwft_wr_pend #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             cap_en,
    input  logic [AW-1:0]    cap_addr,
    input  logic [LANES-1:0] cap_mask,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    rd_addr,
    input  logic [W-1:0]     arr_data,
    output logic             pend_valid,
    output logic [AW-1:0]    pend_addr,
    output logic [LANES-1:0] pend_mask,
    output logic [W-1:0]     pend_data,
    output logic [W-1:0]     merged
);
    // capture write data for the beat registered at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_mask  <= '0;
            pend_data  <= '0;
        end else if (!stall) begin
            pend_valid <= cap_en;
            pend_addr  <= cap_addr;
            pend_mask  <= cap_mask;
            pend_data  <= wdata;
        end
    end

    logic hit;
    assign hit = pend_valid && (pend_addr == rd_addr);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // per-lane choice between pending data and array data
            assign merged[l*LANE_W +: LANE_W] = (hit && pend_mask[l]) ?
                pend_data[l*LANE_W +: LANE_W] : arr_data[l*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/lwft_mem_array.sv
// Storage array: one lane-masked synchronous write port, one combinational read port.
// Assumes DEPTH is a power of two; contents are not reset.
module lwft_mem_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wmask,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    // lane-masked write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wmask[l])
                    mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lwft_sram.sv
// Top: late-write flow-through synchronous SRAM. A command stage registers each
// load or continue; write data is captured one edge later into a pending register
// that commits at the following enabled edge; reads see pending bytes by lane.
// Assumes DEPTH is a power of two and at least 4.
module lwft_sram #(
    parameter int DEPTH        = 64,
    parameter int LANE_W       = 9,
    parameter int LANES        = 2,
    parameter bit LINEAR_BURST = 1'b0,
    localparam int AW          = $clog2(DEPTH),
    localparam int W           = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             adv,
    input  logic             rd_wr_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic             oe_n,
    output logic [W-1:0]     rdata,
    output logic             rdata_drv
);
    lwft_pkg::beat_e  beat;
    logic [AW-1:0]    base;
    logic [1:0]       cnt;
    logic [LANES-1:0] beat_we_n;
    logic [AW-1:0]    beat_addr;
    logic             selected;
    logic             cap_en;
    logic             pend_valid;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic [W-1:0]     pend_data;
    logic [W-1:0]     arr_data;
    logic [W-1:0]     merged;
    logic             commit;

    assign selected = !sel_a_n && sel_b && !sel_c_n;

    lwft_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .rd_wr_n(rd_wr_n),
        .selected(selected), .lane_we_n(lane_we_n), .addr(addr),
        .beat(beat), .base(base), .cnt(cnt), .beat_we_n(beat_we_n)
    );

    lwft_burst_addr #(.AW(AW), .LINEAR(LINEAR_BURST)) u_badr (
        .base(base), .cnt(cnt), .beat_addr(beat_addr)
    );

    // a write beat with every lane disabled captures nothing
    assign cap_en = (beat == lwft_pkg::BEAT_WR) && (beat_we_n != '1);

    lwft_wr_pend #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .stall(stall), .cap_en(cap_en),
        .cap_addr(beat_addr), .cap_mask(~beat_we_n), .wdata(wdata),
        .rd_addr(beat_addr), .arr_data(arr_data),
        .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_mask(pend_mask),
        .pend_data(pend_data), .merged(merged)
    );

    assign commit = pend_valid && !stall && rst_n;

    lwft_mem_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .wr_en(commit), .waddr(pend_addr), .wmask(pend_mask),
        .wdata(pend_data), .raddr(beat_addr), .rdata(arr_data)
    );

    // drive only on read beats with the output enable active
    assign rdata_drv = (beat == lwft_pkg::BEAT_RD) && !oe_n;
    assign rdata     = rdata_drv ? merged : '0;
endmodule

// File: rtl/lwft_sram_chk.sv
// Checker for lwft_sram, attached by bind. Observes ports and the pending flag.
module lwft_sram_chk #(
    parameter int W     = 18,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             adv,
    input logic             rd_wr_n,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic [LANES-1:0] lane_we_n,
    input logic             oe_n,
    input logic [W-1:0]     rdata,
    input logic             rdata_drv,
    input logic             pend_valid
);
    logic sel_ok;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !rdata_drv); // R1

    AST_READ_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && sel_ok && rd_wr_n && !stall) |=> (rdata_drv == !oe_n)); // R2

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !sel_ok && !stall) |=> !rdata_drv); // R5

    AST_ABORT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && sel_ok && !rd_wr_n && (lane_we_n == '1) && !stall) ##1 !stall
        |=> !pend_valid); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && rdata_drv) |=> (oe_n || $stable(rdata))); // R9

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && sel_ok && !rd_wr_n && !stall) |=> !rdata_drv); // R10
endmodule

bind lwft_sram lwft_sram_chk #(.W(W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .rd_wr_n(rd_wr_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv), .pend_valid(pend_valid)
);

// File: tb/tb_lwft_sram.sv
`timescale 1ns/1ps
module tb_lwft_sram;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int W     = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, stall = 1'b0, adv = 1'b0, rd_wr_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic [1:0]    lane_we_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic          oe_n = 1'b0;
    logic [W-1:0]  rdata;
    logic          rdata_drv;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lwft_sram dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .rd_wr_n(rd_wr_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .lane_we_n(lane_we_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    // reference model state (0 idle, 1 read, 2 write)
    int            m_mode = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [1:0]    m_be = 2'b11;
    logic [W-1:0]  ref_mem [DEPTH];
    logic [1:0]    known [DEPTH];

    initial for (int i = 0; i < DEPTH; i++) known[i] = 2'b00;

    function automatic logic [AW-1:0] m_addr();
        return {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
    endfunction

    // one rising edge of the reference model, using the inputs held across it
    task automatic model_edge();
        logic [AW-1:0] a;
        if (!rst_n) begin
            m_mode = 0; m_base = '0; m_cnt = '0; m_be = 2'b11;
        end else if (!stall) begin
            a = m_addr();
            if (m_mode == 2) begin
                if (!m_be[0]) begin ref_mem[a][8:0]  = wdata[8:0];  known[a][0] = 1'b1; end
                if (!m_be[1]) begin ref_mem[a][17:9] = wdata[17:9]; known[a][1] = 1'b1; end
            end
            m_be = lane_we_n;
            if (!adv) begin
                m_base = addr; m_cnt = '0;
                if (sel_a_n || !sel_b || sel_c_n) m_mode = 0;
                else m_mode = rd_wr_n ? 1 : 2;
            end else begin
                m_cnt = m_cnt + 2'd1;
            end
        end
    endtask

    task automatic check(input string tag, input logic edrv, input logic [W-1:0] edata,
                         input logic [W-1:0] emask);
        n_chk++;
        if (rdata_drv !== edrv || (edrv && ((rdata & emask) !== (edata & emask)))) begin
            n_bad++;
            $display("FAIL %s: drv=%0b data=%05h expected drv=%0b data=%05h",
                     tag, rdata_drv, rdata, edrv, edata & emask);
        end
    endtask

    task automatic set_in(input logic st, input logic ad, input logic rw, input logic [1:0] ds,
                          input logic [1:0] be, input logic [AW-1:0] a, input logic [W-1:0] wd,
                          input logic oe);
        stall = st; adv = ad; rd_wr_n = rw; lane_we_n = be; addr = a; wdata = wd; oe_n = oe;
        sel_a_n = (ds == 2'd1); sel_b = (ds != 2'd2); sel_c_n = (ds == 2'd3);
    endtask

    // one edge: model advances, outputs settle, then sampling 3 ns after the edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        #3;
    endtask

    task automatic model_check(input string tag);
        logic [AW-1:0] a;
        logic [W-1:0]  mk;
        a  = m_addr();
        mk = {{9{known[a][1]}}, {9{known[a][0]}}};
        check(tag, (m_mode == 1) && !oe_n, ref_mem[a], mk);
    endtask

    typedef struct packed {
        logic          st;
        logic          ad;
        logic          rw;
        logic [1:0]    ds;
        logic [1:0]    be;
        logic [5:0]    a;
        logic [17:0]   wd;
        logic          oe;
        logic          edrv;
        logic [17:0]   edata;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 6'd5, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R3 write 5
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd5, 18'h12345, 1'b0, 1'b1, 18'h12345}, // R4 bypass
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 6'd6, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R10 write
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'b10, 6'd6, 18'h0F0F0, 1'b0, 1'b0, 18'h00000}, // R11 lane 0 only
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd6, 18'h3FFFF, 1'b0, 1'b1, 18'h0F1FF}, // R11 merge
        '{1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 6'd5, 18'h00000, 1'b0, 1'b1, 18'h0F1FF}, // R9 stall
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'b11, 6'd5, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R8 abort
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd5, 18'h00777, 1'b0, 1'b1, 18'h12345}, // R8 unchanged
        '{1'b0, 1'b0, 1'b1, 2'd1, 2'b00, 6'd5, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R5 deselect
        '{1'b0, 1'b1, 1'b1, 2'd0, 2'b00, 6'd5, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R7 continue
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd5, 18'h00000, 1'b1, 1'b0, 18'h00000}, // R10 oe_n high
        '{1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 6'd0, 18'h00000, 1'b0, 1'b1, 18'h12345}, // R9 hold read
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 6'd5, 18'h00000, 1'b0, 1'b0, 18'h00000}, // R10 write beat
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd5, 18'h2AAAA, 1'b0, 1'b1, 18'h2AAAA}  // R2 R4 read
    };

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [W-1:0] BD [4] = '{18'h11111, 18'h22222, 18'h33333, 18'h04444};

    initial begin : main
        // R1: reset state
        set_in(1'b0, 1'b0, 1'b1, 2'd0, 2'b11, '0, '0, 1'b0);
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 reset idle", 1'b0, '0, '1);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            set_in(VECS[i].st, VECS[i].ad, VECS[i].rw, VECS[i].ds, VECS[i].be,
                   VECS[i].a, VECS[i].wd, VECS[i].oe);
            tick();
            check($sformatf("table row %0d", i), VECS[i].edrv, VECS[i].edata, '1);
        end

        // R6: write burst from 8 (offsets 0,1,2,3), then read burst from 10 with wrap
        set_in(1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 6'd8, '0, 1'b0);
        tick();
        for (int b = 0; b < 3; b++) begin
            set_in(1'b0, 1'b1, 1'b1, 2'd1, 2'b00, 6'd0, BD[b], 1'b0); // selects/rw ignored
            tick();
            check("R6 write burst no drive", 1'b0, '0, '1);
        end
        set_in(1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd10, BD[3], 1'b0);
        tick();
        check("R6 burst beat0 addr10", 1'b1, BD[2], '1);
        for (int b = 1; b < 5; b++) begin
            set_in(1'b0, 1'b1, 1'b0, 2'd3, 2'b00, 6'd0, '0, 1'b0); // ignored on continue
            tick();
            // XOR order from 10: 10,11,8,9, then wrap to 10
            check($sformatf("R6 burst beat%0d", b), 1'b1, BD[(2 ^ (b % 4))], '1);
        end

        // R1: reset in the middle of a read
        rst_n = 1'b0;
        set_in(1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 6'd10, '0, 1'b0);
        tick();
        check("R1 reset mid read", 1'b0, '0, '1);
        rst_n = 1'b1;

        // random mix checked against the model: R2 R3 R4 R5 R6 R8 R9 R10 R11
        for (int c = 0; c < 3000; c++) begin
            set_in(($urandom % 8) == 0, ($urandom % 3) == 0, $urandom % 2,
                   (($urandom % 8) == 0) ? 2'(1 + $urandom % 3) : 2'd0,
                   2'($urandom), 6'($urandom % 16), 18'($urandom),
                   ($urandom % 8) == 0);
            tick();
            model_check("R2 R4 R9 random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule